// File: doc/BRIEF.md
# Priority Read Return Scheduler

This block sits on the system side of a point-to-point graphics link and schedules the return of completed read data to the graphics master. Read completions arrive from the memory side as streams of 64-bit quad-word beats. Each completion ends with a beat that carries a last flag. Completions wait in one of two queues, high priority or low priority, and each queue keeps its arrival order.

The scheduler grants the return data bus to one completion at a time. In the single grant cycle it drives a 3-bit status code that tells the master which queue the data comes from, so the master can route every beat. The master can pause low-priority traffic by pulling its active-low buffer-full input low. High-priority returns are not affected by that signal.

Beats move under a two-sided ready handshake, and either side may hold a beat back. The target side holds a beat back when its queue has run dry in the middle of a completion. After the last beat of each completion the scheduler leaves one dead cycle before the bus can be handed over again.

Top module: `rd_return_sched`

## Requirements
- R1: In the cycle `bus_gnt` is high, `bus_status` is 3'b001 for a high-priority completion and 3'b000 for a low-priority completion.
- R2: In every cycle where `bus_gnt` is low, `bus_status` is 3'b111.
- R3: `bus_gnt` is a single-cycle pulse and `tgt_rdy` is never high in a grant cycle; the first beat can be offered one cycle after the grant.
- R4: When `buf_full_n` is low in the idle decision cycle, no low-priority completion is granted in the following cycle; a pending high-priority completion is granted regardless.
- R5: When both queues are eligible in the decision cycle, the high-priority completion is granted.
- R6: Once granted, a completion runs until its last beat is accepted; no new grant occurs in between.
- R7: Each queue returns its beats, including the last flag, in the order they were pushed.
- R8: A beat is consumed only on a clock edge where both `tgt_rdy` and `mst_rdy` are high; `tgt_rdy` is low while the selected queue is empty, and an offered beat stays unchanged until it is consumed.
- R9: The cycle after the last beat is accepted is a dead cycle with `bus_gnt` and `tgt_rdy` both low; the next grant comes no earlier than the third cycle after the last beat.
- R10: While `rst_n` is low, `bus_gnt` and `tgt_rdy` are low, `bus_status` is 3'b111 and both full flags are low.
- R11: A queue's full flag is high exactly when it holds its depth in beats (8 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| hi_in_valid | input | 1 | Push one beat into the high-priority queue |
| hi_in_data | input | DATA_W | Beat payload for the high-priority queue |
| hi_in_last | input | 1 | Pushed beat ends a high-priority completion |
| hi_in_full | output | 1 | High-priority queue full; pushes are dropped |
| lo_in_valid | input | 1 | Push one beat into the low-priority queue |
| lo_in_data | input | DATA_W | Beat payload for the low-priority queue |
| lo_in_last | input | 1 | Pushed beat ends a low-priority completion |
| lo_in_full | output | 1 | Low-priority queue full; pushes are dropped |
| buf_full_n | input | 1 | Master read buffer full, active low; stalls low-priority starts |
| mst_rdy | input | 1 | Master ready to accept the offered beat |
| bus_gnt | output | 1 | One-cycle grant at the start of a completion |
| bus_status | output | 3 | Transfer type code, valid with the grant |
| tgt_rdy | output | 1 | Target offers a valid beat |
| bus_data | output | DATA_W | Offered beat payload |
| bus_last | output | 1 | Offered beat is the last of its completion |

## Verification
Every result has a fixed cycle: the grant appears one cycle after the idle cycle in which the queues and `buf_full_n` are sampled. The first beat can be offered in the cycle after the grant. A beat is consumed on the edge where both ready signals are high, and the dead cycle follows the last beat directly. The bench keeps a behavioural model that advances on the same rising edges from the same sampled inputs. It compares every output on the falling edge, where the design's registered outputs have settled. Stimulus stages cover a held buffer-full, throttling on both sides and queues filled to their depth.

// File: rtl/rrs_pkg.sv
// Package: shared codes and types for the read return scheduler.
// Assumes: status codes are fixed by the link protocol; phase order is the
// transfer sequence idle -> grant -> data -> dead cycle.
package rrs_pkg;

    localparam logic [2:0] ST_LO_READ = 3'b000;
    localparam logic [2:0] ST_HI_READ = 3'b001;
    localparam logic [2:0] ST_REQUEST = 3'b111;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_GRANT = 2'd1,
        PH_XFER  = 2'd2,
        PH_TURN  = 2'd3
    } phase_t;

    typedef enum logic {
        Q_LO = 1'b0,
        Q_HI = 1'b1
    } qsel_t;

endpackage

// File: rtl/rrs_fifo.sv
// Module: first-in first-out beat store for one priority class.
// Assumes: a push while full and a pop while empty are dropped; the head is
// valid whenever empty is low; DEPTH may be any value of 2 or more.
module rrs_fifo #(
    parameter int W     = 65,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign head    = mem[rd_ptr];

    // Pointer advance: free wrap for power-of-two depth, explicit wrap otherwise.
    generate
        if (DEPTH == (1 << AW)) begin : g_pow2
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_wrap
            assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_nxt;
            if (do_pop)  rd_ptr <= rd_nxt;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (!do_push && do_pop) count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/rrs_pick.sv
// Module: priority choice between the two queues for the next completion.
// Assumes: evaluated only while the bus is idle; a low-priority start needs
// the master's buffer-full signal deasserted (high), a high one does not.
module rrs_pick (
    input  logic hi_empty,
    input  logic lo_empty,
    input  logic buf_full_n,
    output logic start,
    output logic pick_hi
);

    logic hi_ok, lo_ok;

    // Eligibility per class and fixed high-over-low preference.
    always_comb begin
        hi_ok   = !hi_empty;
        lo_ok   = !lo_empty && buf_full_n;
        start   = hi_ok || lo_ok;
        pick_hi = hi_ok;
    end

endmodule

// File: rtl/rrs_seq.sv
// Module: transfer sequencer: idle decision, one grant cycle, data beats,
// one dead cycle.
// Assumes: the chosen queue is held for the whole completion; a beat moves
// when the selected queue is non-empty and the master is ready.
module rrs_seq
    import rrs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   pick_hi,
    input  logic   sel_avail,
    input  logic   sel_last,
    input  logic   mst_rdy,
    output phase_t phase,
    output qsel_t  sel,
    output logic   beat_done
);

    // A beat is consumed when both sides are ready in the data phase.
    always_comb begin
        beat_done = (phase == PH_XFER) && sel_avail && mst_rdy;
    end

    // Phase progression and queue latch at the start of each completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            sel   <= Q_LO;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_GRANT;
                        sel   <= pick_hi ? Q_HI : Q_LO;
                    end
                end
                PH_GRANT: phase <= PH_XFER;
                PH_XFER:  if (beat_done && sel_last) phase <= PH_TURN;
                PH_TURN:  phase <= PH_IDLE;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rd_return_sched.sv
// Module: top of the priority read return scheduler.
// Assumes: completions are pushed beat by beat with a last flag; pushes to a
// full queue are dropped; outputs depend only on registered state.
module rd_return_sched
    import rrs_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int HI_DEPTH = 8,
    parameter int LO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_in_valid,
    input  logic [DATA_W-1:0] hi_in_data,
    input  logic              hi_in_last,
    output logic              hi_in_full,
    input  logic              lo_in_valid,
    input  logic [DATA_W-1:0] lo_in_data,
    input  logic              lo_in_last,
    output logic              lo_in_full,
    input  logic              buf_full_n,
    input  logic              mst_rdy,
    output logic              bus_gnt,
    output logic [2:0]        bus_status,
    output logic              tgt_rdy,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_last
);

    localparam int EW = DATA_W + 1;

    logic [EW-1:0] hi_head, lo_head, sel_head;
    logic          hi_empty, lo_empty;
    logic          start, pick_hi;
    logic          sel_avail, beat_done;
    phase_t        phase;
    qsel_t         sel;

    rrs_fifo #(.W(EW), .DEPTH(HI_DEPTH)) u_hi_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (hi_in_valid),
        .wdata ({hi_in_last, hi_in_data}),
        .pop   (beat_done && (sel == Q_HI)),
        .head  (hi_head),
        .empty (hi_empty),
        .full  (hi_in_full)
    );

    rrs_fifo #(.W(EW), .DEPTH(LO_DEPTH)) u_lo_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (lo_in_valid),
        .wdata ({lo_in_last, lo_in_data}),
        .pop   (beat_done && (sel == Q_LO)),
        .head  (lo_head),
        .empty (lo_empty),
        .full  (lo_in_full)
    );

    rrs_pick u_pick (
        .hi_empty   (hi_empty),
        .lo_empty   (lo_empty),
        .buf_full_n (buf_full_n),
        .start      (start),
        .pick_hi    (pick_hi)
    );

    rrs_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .pick_hi   (pick_hi),
        .sel_avail (sel_avail),
        .sel_last  (sel_head[EW-1]),
        .mst_rdy   (mst_rdy),
        .phase     (phase),
        .sel       (sel),
        .beat_done (beat_done)
    );

    // Route the selected queue's head to the data bus.
    always_comb begin
        sel_head  = (sel == Q_HI) ? hi_head : lo_head;
        sel_avail = (sel == Q_HI) ? !hi_empty : !lo_empty;
    end

    // Bus-side outputs derived from the phase and the held selection.
    always_comb begin
        bus_gnt    = (phase == PH_GRANT);
        bus_status = ST_REQUEST;
        if (phase == PH_GRANT) begin
            bus_status = (sel == Q_HI) ? ST_HI_READ : ST_LO_READ;
        end
        tgt_rdy  = (phase == PH_XFER) && sel_avail;
        bus_data = sel_head[DATA_W-1:0];
        bus_last = sel_head[EW-1];
    end

endmodule

// File: rtl/rrs_checker.sv
// Module: protocol checker for the read return scheduler, bound to the top.
// Assumes: observes ports only, plus one tracking flag of its own.
module rrs_checker #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              buf_full_n,
    input logic              mst_rdy,
    input logic              bus_gnt,
    input logic [2:0]        bus_status,
    input logic              tgt_rdy,
    input logic [DATA_W-1:0] bus_data,
    input logic              bus_last
);

    logic in_xfer;

    // Track whether a granted completion has not yet delivered its last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_xfer <= 1'b0;
        end else if (bus_gnt) begin
            in_xfer <= 1'b1;
        end else if (tgt_rdy && mst_rdy && bus_last) begin
            in_xfer <= 1'b0;
        end
    end

    a_r1_grant_code: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gnt |-> (bus_status == 3'b000 || bus_status == 3'b001));

    a_r2_request_code: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_gnt |-> (bus_status == 3'b111));

    a_r3_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gnt |=> !bus_gnt);

    a_r3_no_beat_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gnt |-> !tgt_rdy);

    a_r4_low_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_status == 3'b000) |-> $past(buf_full_n));

    a_r6_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gnt |-> !in_xfer);

    a_r8_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_rdy && !mst_rdy) |=> (tgt_rdy && $stable(bus_data) && $stable(bus_last)));

    a_r9_dead_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_rdy && mst_rdy && bus_last) |=> (!tgt_rdy && !bus_gnt));

endmodule

bind rd_return_sched rrs_checker #(.DATA_W(DATA_W)) u_rrs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .buf_full_n (buf_full_n),
    .mst_rdy    (mst_rdy),
    .bus_gnt    (bus_gnt),
    .bus_status (bus_status),
    .tgt_rdy    (tgt_rdy),
    .bus_data   (bus_data),
    .bus_last   (bus_last)
);

// File: tb/rd_return_sched_tb_top.sv
`timescale 1ns/1ps
module rd_return_sched_tb_top;

    localparam int DW    = 64;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hi_in_valid = 1'b0, lo_in_valid = 1'b0;
    logic [DW-1:0] hi_in_data = '0, lo_in_data = '0;
    logic          hi_in_last = 1'b0, lo_in_last = 1'b0;
    logic          hi_in_full, lo_in_full;
    logic          buf_full_n = 1'b1;
    logic          mst_rdy = 1'b1;
    logic          bus_gnt, tgt_rdy, bus_last;
    logic [2:0]    bus_status;
    logic [DW-1:0] bus_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rd_return_sched #(.DATA_W(DW), .HI_DEPTH(DEPTH), .LO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .hi_in_valid(hi_in_valid), .hi_in_data(hi_in_data), .hi_in_last(hi_in_last), .hi_in_full(hi_in_full),
        .lo_in_valid(lo_in_valid), .lo_in_data(lo_in_data), .lo_in_last(lo_in_last), .lo_in_full(lo_in_full),
        .buf_full_n(buf_full_n), .mst_rdy(mst_rdy),
        .bus_gnt(bus_gnt), .bus_status(bus_status), .tgt_rdy(tgt_rdy),
        .bus_data(bus_data), .bus_last(bus_last)
    );

    // Behavioural reference: queues of {last, data}, phase 0 idle, 1 grant, 2 data, 3 dead.
    logic [DW:0] hq[$];
    logic [DW:0] lq[$];
    int m_ph = 0;
    bit m_sel = 1'b0;      // 1 = high-priority completion
    bit m_lo_also = 1'b0;  // low was also eligible when high was chosen
    bit m_lo_block = 1'b0; // low was pending but held off by buffer-full

    task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Reference model step on each rising edge, from inputs driven at the falling edge.
    always @(posedge clk) begin
        int hs, ls;
        if (!rst_n) begin
            hq.delete(); lq.delete();
            m_ph = 0; m_sel = 1'b0; m_lo_also = 1'b0; m_lo_block = 1'b0;
        end else begin
            hs = hq.size(); ls = lq.size();
            case (m_ph)
                0: begin
                    m_lo_block = (ls > 0) && !buf_full_n;
                    if (hs > 0) begin
                        m_ph = 1; m_sel = 1'b1; m_lo_also = (ls > 0) && buf_full_n;
                    end else if (ls > 0 && buf_full_n) begin
                        m_ph = 1; m_sel = 1'b0; m_lo_also = 1'b0;
                    end
                end
                1: m_ph = 2;
                2: begin
                    if (m_sel && hs > 0 && mst_rdy) begin
                        if (hq[0][DW]) m_ph = 3;
                        void'(hq.pop_front());
                    end else if (!m_sel && ls > 0 && mst_rdy) begin
                        if (lq[0][DW]) m_ph = 3;
                        void'(lq.pop_front());
                    end
                end
                default: m_ph = 0;
            endcase
            if (m_ph != 0) m_lo_block = 1'b0;
            if (hi_in_valid && hs < DEPTH) hq.push_back({hi_in_last, hi_in_data});
            if (lo_in_valid && ls < DEPTH) lq.push_back({lo_in_last, lo_in_data});
        end
    end

    // Compare every output against the reference on the falling edge.
    always @(negedge clk) begin
        logic       e_gnt, e_rdy;
        logic [2:0] e_st;
        logic [DW:0] e_head;
        string      t;
        if (rst_n && !done) begin
            e_gnt = (m_ph == 1);
            e_st  = (m_ph == 1) ? (m_sel ? 3'b001 : 3'b000) : 3'b111;
            if (m_ph == 1)      t = (m_sel && m_lo_also) ? "R5" : "R1";
            else if (m_ph == 3) t = "R9";
            else if (m_ph == 2) t = "R6";
            else if (m_lo_block) t = "R4";
            else                t = "R2";
            chk({bus_gnt, bus_status} == {e_gnt, e_st}, t, 72'({bus_gnt, bus_status}), 72'({e_gnt, e_st}));
            e_rdy = (m_ph == 2) && (m_sel ? hq.size() > 0 : lq.size() > 0);
            chk(tgt_rdy == e_rdy, (m_ph == 2) ? "R8" : "R3", 72'(tgt_rdy), 72'(e_rdy));
            if (e_rdy && tgt_rdy) begin
                e_head = m_sel ? hq[0] : lq[0];
                chk({bus_last, bus_data} == e_head, "R7", 72'({bus_last, bus_data}), 72'(e_head));
            end
            chk(hi_in_full == (hq.size() == DEPTH), "R11", 72'(hi_in_full), 72'(hq.size() == DEPTH));
            chk(lo_in_full == (lq.size() == DEPTH), "R11", 72'(lo_in_full), 72'(lq.size() == DEPTH));
        end
    end

    // Watchdog: an overlong run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL R6 watchdog expired act=%0d exp=%0d", cycles, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    int hseq = 0, lseq = 0, hleft = 0, lleft = 0;

    // One stimulus stage: push rates, buffer-full and master-ready percentages.
    task automatic run_stage(input int n, input int hr, input int lr, input int bfp, input int rp);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hi_in_valid = 1'b0; lo_in_valid = 1'b0;
            if (int'($urandom_range(99)) < hr && hq.size() < DEPTH) begin
                if (hleft == 0) hleft = 1 + int'($urandom_range(3));
                hi_in_valid = 1'b1;
                hi_in_data  = {8'hC1, 24'h0, 32'(hseq)};
                hi_in_last  = (hleft == 1);
                hseq++; hleft--;
            end
            if (int'($urandom_range(99)) < lr && lq.size() < DEPTH) begin
                if (lleft == 0) lleft = 1 + int'($urandom_range(3));
                lo_in_valid = 1'b1;
                lo_in_data  = {8'h5A, 24'h0, 32'(lseq)};
                lo_in_last  = (lleft == 1);
                lseq++; lleft--;
            end
            buf_full_n = !(int'($urandom_range(99)) < bfp);
            mst_rdy    = (int'($urandom_range(99)) < rp);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state at the ports
        chk(bus_gnt == 1'b0 && bus_status == 3'b111 && tgt_rdy == 1'b0 && !hi_in_full && !lo_in_full,
            "R10", 72'({bus_gnt, bus_status, tgt_rdy, hi_in_full, lo_in_full}), 72'({1'b0, 3'b111, 3'b000}));
        rst_n = 1'b1;
        run_stage(200, 0, 40, 0, 100);   // low-priority only, free flow
        run_stage(200, 30, 30, 0, 100);  // both classes, priority contention (R5)
        run_stage(60, 0, 80, 100, 100);  // buffer-full held: low queue fills (R4, R11)
        run_stage(150, 40, 50, 100, 100);// high still flows under buffer-full (R4)
        run_stage(400, 40, 40, 0, 50);   // master throttling (R8)
        run_stage(600, 35, 35, 40, 70);  // mixed buffer-full and throttling
        run_stage(500, 10, 10, 20, 90);  // sparse pushes: target throttles mid-completion
        for (int k = 0; k < 2000 && (hq.size() > 0 || lq.size() > 0 || hleft > 0 || lleft > 0 || m_ph != 0); k++) begin
            run_stage(1, (hleft > 0) ? 100 : 0, (lleft > 0) ? 100 : 0, 0, 100);
        end
        run_stage(5, 0, 0, 0, 100);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule